// File: doc/BRIEF.md
# Debug Execution Control and Match Unit

This block sits next to a small 8-bit processor and decides, cycle by cycle, whether the processor may advance. A host drives a narrow register port to issue execution commands: resume, stop, execute one instruction, or pass over one instruction without executing it. The same port programs one code-address comparator and a parameterised set of data-access comparators.

The code comparator watches the instruction-fetch address. Each data comparator watches the processor's data bus. That bus carries an address space tag for internal data memory, external data memory or the special-register space, a direction, an address and a data byte. A comparator can also require a data value. Any hit stops a running processor and sets a sticky cause flag. The flag stays set until the host writes a one to clear it.

Two live status outputs show the processor executing and a debugger-originated memory access in progress. When no comparator is enabled, the compare logic is held idle and a power-save indication drops.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: After reset the unit is in the running state (`code_running`=1, state code 0). All comparators are disabled, every cause flag is 0, and `cpu_skip`, `debug_access` and `cmp_awake` are 0.
- R2: A write to register 0 carries a command in bits [2:0]: 1 run, 2 halt, 3 step, 4 skip, 5 debug access. Halt takes a running or stepping unit to the halted state (state code 1), and `code_running` is 0 from the next cycle. Run takes a halted unit back to running (state code 0).
- R3: Step, issued while halted, raises `code_running` from the next cycle. The unit stays in the stepping state (code 2) until `instr_done` is sampled high, and it is halted from the following cycle.
- R4: Skip, issued while halted, raises `cpu_skip` for exactly one cycle (state code 3) while `code_running` stays 0. The unit then returns to halted.
- R5: A command that does not apply in the current state has no effect. This covers step, skip and access while running, run while running, and run, step or skip while a debug access is outstanding.
- R6: Register 3 bit 0 enables the code comparator, and register 2 holds its address. While running, a fetch (`fetch_valid`) at that address halts the unit from the next cycle and sets cause bit 0. A fetch at that address while stepping does not halt the unit.
- R7: Data comparator i is configured at register 4+2i (address) and register 5+2i. In 5+2i, bits [1:0] select the access kind (00 off, 01 read, 10 write, 11 either) and bits [3:2] select the space (00 internal data, 01 external data, 10 special registers). While running, an access matching kind, space and address halts the unit from the next cycle. A read hit sets cause bit 1 and a write hit sets cause bit 2. Hits while stepping set cause bits only.
- R8: Bit 4 of the data comparator configuration enables a data condition. When set, a hit also requires the bus data to equal bits [15:8]; when clear, the data is ignored.
- R9: Register 1 reads as cause flags in [2:0], state code in [5:4] and the access-busy flag in [6]. Cause flags stay set until a one is written to the same bit of register 1. A hit in the same cycle as the clear wins.
- R10: An access command while halted raises `debug_access` from the next cycle. It stays high through the cycle in which `dbg_ack` is sampled and is low from the following cycle.
- R11: `cmp_awake` is 1 exactly when the code comparator is enabled or any data comparator kind is non-zero. While it is 0, no access or fetch produces a hit.
- R12: Configuration registers read back what was written, with unimplemented bits reading 0. Register 0 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| fetch_valid | input | 1 | Instruction fetch in progress |
| fetch_addr | input | 16 | Instruction fetch address |
| instr_done | input | 1 | Processor finished an instruction |
| acc_valid | input | 1 | Data access on the bus |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_space | input | 2 | Address space of the access |
| acc_addr | input | 16 | Access address |
| acc_data | input | 8 | Access data byte |
| dbg_ack | input | 1 | Debugger-originated access completed |
| code_running | output | 1 | Processor is allowed to execute |
| cpu_skip | output | 1 | Advance the program counter past the current instruction |
| debug_access | output | 1 | Debugger access in progress |
| cmp_awake | output | 1 | Compare logic active (not in power save) |

## Verification
Commands and hits are sampled on a rising edge. The state, busy flag and cause flags change on that edge, so `code_running`, `cpu_skip`, `debug_access` and register 1 show the result one cycle after the stimulus. Register writes change `host_rdata` and `cmp_awake` on that same edge. The bench drives inputs just after a rising edge and updates a behavioural model on that edge from the same inputs. It compares every output and the read port on the following falling edge, so each result is checked in the cycle it is due and in every cycle after.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STEP = 2'd2,
        ST_SKIP = 2'd3
    } run_state_e;

    localparam logic [2:0] CMD_NONE   = 3'd0;
    localparam logic [2:0] CMD_RUN    = 3'd1;
    localparam logic [2:0] CMD_HALT   = 3'd2;
    localparam logic [2:0] CMD_STEP   = 3'd3;
    localparam logic [2:0] CMD_SKIP   = 3'd4;
    localparam logic [2:0] CMD_ACCESS = 3'd5;

    localparam int REG_CMD     = 0;
    localparam int REG_STATUS  = 1;
    localparam int REG_BP_ADDR = 2;
    localparam int REG_BP_CFG  = 3;
    localparam int REG_WP_BASE = 4;

    localparam int CAUSE_CODE = 0;
    localparam int CAUSE_RD   = 1;
    localparam int CAUSE_WR   = 2;

    typedef struct packed {
        logic       pat_en;
        logic [1:0] space;
        logic [1:0] kind;
    } wp_cfg_t;

endpackage

// File: rtl/dbg_wp_match.sv
module dbg_wp_match #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic               armed,
    input  dbg_pkg::wp_cfg_t   cfg,
    input  logic [AW-1:0]      wp_addr,
    input  logic [DW-1:0]      wp_pat,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_space,
    input  logic [AW-1:0]      acc_addr,
    input  logic [DW-1:0]      acc_data,
    output logic               hit_rd,
    output logic               hit_wr
);
    logic base_match;
    logic data_ok;

    always_comb begin
        data_ok    = !cfg.pat_en || (acc_data == wp_pat);
        base_match = armed && acc_valid && (acc_space == cfg.space)
                     && (acc_addr == wp_addr) && data_ok;
        hit_rd     = base_match && !acc_write && cfg.kind[0];
        hit_wr     = base_match &&  acc_write && cfg.kind[1];
    end
endmodule

// File: rtl/dbg_host_regs.sv
module dbg_host_regs #(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int NUM_WP = 2,
    parameter int HAW    = 4,
    parameter int HDW    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [HAW-1:0]                host_addr,
    input  logic [HDW-1:0]                host_wdata,
    output logic [HDW-1:0]                host_rdata,
    input  logic [1:0]                    state_code,
    input  logic                          busy,
    input  logic [2:0]                    hit_vec,
    output logic [2:0]                    cmd,
    output logic [AW-1:0]                 bp_addr,
    output logic                          bp_en,
    output logic [NUM_WP-1:0][AW-1:0]     wp_addr,
    output dbg_pkg::wp_cfg_t [NUM_WP-1:0] wp_cfg,
    output logic [NUM_WP-1:0][DW-1:0]     wp_pat
);
    import dbg_pkg::*;

    localparam int PAT_LSB = 8;

    typedef struct packed {
        logic [AW-1:0]             bp_addr;
        logic                      bp_en;
        logic [NUM_WP-1:0][AW-1:0] wp_addr;
        wp_cfg_t [NUM_WP-1:0]      wp_cfg;
        logic [NUM_WP-1:0][DW-1:0] wp_pat;
        logic [2:0]                cause;
    } regs_t;

    regs_t q, d;
    logic  status_wr;
    logic  unused_wdata;

    assign unused_wdata = ^host_wdata;

    always_comb begin
        d         = q;
        status_wr = host_we && (host_addr == HAW'(REG_STATUS));
        cmd       = (host_we && host_addr == HAW'(REG_CMD)) ? host_wdata[2:0] : CMD_NONE;
        if (host_we && host_addr == HAW'(REG_BP_ADDR)) d.bp_addr = host_wdata[AW-1:0];
        if (host_we && host_addr == HAW'(REG_BP_CFG))  d.bp_en   = host_wdata[0];
        for (int i = 0; i < NUM_WP; i++) begin
            if (host_we && host_addr == HAW'(REG_WP_BASE + 2*i))
                d.wp_addr[i] = host_wdata[AW-1:0];
            if (host_we && host_addr == HAW'(REG_WP_BASE + 2*i + 1)) begin
                d.wp_cfg[i].kind   = host_wdata[1:0];
                d.wp_cfg[i].space  = host_wdata[3:2];
                d.wp_cfg[i].pat_en = host_wdata[4];
                d.wp_pat[i]        = host_wdata[PAT_LSB +: DW];
            end
        end
        d.cause = (q.cause & ~(status_wr ? host_wdata[2:0] : 3'b000)) | hit_vec;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == HAW'(REG_STATUS))
            host_rdata = HDW'({busy, state_code, 1'b0, q.cause});
        if (host_addr == HAW'(REG_BP_ADDR)) host_rdata = HDW'(q.bp_addr);
        if (host_addr == HAW'(REG_BP_CFG))  host_rdata = HDW'(q.bp_en);
        for (int i = 0; i < NUM_WP; i++) begin
            if (host_addr == HAW'(REG_WP_BASE + 2*i))
                host_rdata = HDW'(q.wp_addr[i]);
            if (host_addr == HAW'(REG_WP_BASE + 2*i + 1)) begin
                host_rdata[4:0]           = q.wp_cfg[i];
                host_rdata[PAT_LSB +: DW] = q.wp_pat[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bp_addr = q.bp_addr;
    assign bp_en   = q.bp_en;
    assign wp_addr = q.wp_addr;
    assign wp_cfg  = q.wp_cfg;
    assign wp_pat  = q.wp_pat;

    // R9
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_wr |=> ((q.cause & $past(q.cause)) == $past(q.cause)));

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> ($stable(q.bp_addr) && $stable(q.wp_cfg) && $stable(q.bp_en)));
endmodule

// File: rtl/dbg_exec_fsm.sv
module dbg_exec_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd,
    input  logic                bp_hit,
    input  logic                wp_hit,
    input  logic                instr_done,
    input  logic                dbg_ack,
    output dbg_pkg::run_state_e state,
    output logic                busy,
    output logic                code_running,
    output logic                cpu_skip,
    output logic                debug_access
);
    import dbg_pkg::*;

    typedef struct packed {
        run_state_e st;
        logic       busy;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        if (q.busy && dbg_ack) d.busy = 1'b0;
        unique case (q.st)
            ST_RUN:  if (cmd == CMD_HALT || bp_hit || wp_hit) d.st = ST_HALT;
            ST_STEP: if (cmd == CMD_HALT || instr_done)       d.st = ST_HALT;
            ST_SKIP: d.st = ST_HALT;
            ST_HALT: begin
                if (!q.busy) begin
                    unique case (cmd)
                        CMD_RUN:    d.st   = ST_RUN;
                        CMD_STEP:   d.st   = ST_STEP;
                        CMD_SKIP:   d.st   = ST_SKIP;
                        CMD_ACCESS: d.busy = 1'b1;
                        default:    ;
                    endcase
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RUN, busy: 1'b0};
        else        q <= d;
    end

    assign state        = q.st;
    assign busy         = q.busy;
    assign code_running = (q.st == ST_RUN) || (q.st == ST_STEP);
    assign cpu_skip     = (q.st == ST_SKIP);
    assign debug_access = q.busy;

    // R4
    skip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_skip |=> (!cpu_skip && !code_running));

    // R10
    access_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debug_access |-> !code_running);

    // R3
    step_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STEP && instr_done) |=> (state == ST_HALT));

    // R2
    halt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_running && cmd == CMD_HALT) |=> !code_running);
endmodule

// File: rtl/dbg_ctrl_unit.sv
module dbg_ctrl_unit #(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int NUM_WP = 2,
    parameter int HAW    = 4,
    parameter int HDW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [HAW-1:0]  host_addr,
    input  logic [HDW-1:0]  host_wdata,
    output logic [HDW-1:0]  host_rdata,
    input  logic            fetch_valid,
    input  logic [AW-1:0]   fetch_addr,
    input  logic            instr_done,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [1:0]      acc_space,
    input  logic [AW-1:0]   acc_addr,
    input  logic [DW-1:0]   acc_data,
    input  logic            dbg_ack,
    output logic            code_running,
    output logic            cpu_skip,
    output logic            debug_access,
    output logic            cmp_awake
);
    import dbg_pkg::*;

    localparam int REG_SPAN = REG_WP_BASE + 2*NUM_WP;
    initial begin
        if (REG_SPAN > (1 << HAW)) $error("register map exceeds host address space");
        if (HDW < 8 + DW || HDW < AW) $error("host data width too small");
    end

    logic [2:0]                    cmd;
    logic [AW-1:0]                 bp_addr;
    logic                          bp_en;
    logic [NUM_WP-1:0][AW-1:0]     wp_addr;
    wp_cfg_t [NUM_WP-1:0]          wp_cfg;
    logic [NUM_WP-1:0][DW-1:0]     wp_pat;
    run_state_e                    state;
    logic                          busy;
    logic [NUM_WP-1:0]             rd_hits, wr_hits;
    logic                          bp_hit, wp_hit, wp_armed;
    logic [2:0]                    hit_vec;

    always_comb begin
        cmp_awake = bp_en;
        for (int i = 0; i < NUM_WP; i++) cmp_awake = cmp_awake | (|wp_cfg[i].kind);
    end

    assign wp_armed = cmp_awake && (state == ST_RUN || state == ST_STEP);
    assign bp_hit   = cmp_awake && bp_en && (state == ST_RUN)
                      && fetch_valid && (fetch_addr == bp_addr);

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        dbg_wp_match #(.AW(AW), .DW(DW)) u_match (
            .armed     (wp_armed),
            .cfg       (wp_cfg[g]),
            .wp_addr   (wp_addr[g]),
            .wp_pat    (wp_pat[g]),
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .acc_space (acc_space),
            .acc_addr  (acc_addr),
            .acc_data  (acc_data),
            .hit_rd    (rd_hits[g]),
            .hit_wr    (wr_hits[g])
        );
    end

    assign wp_hit  = (|rd_hits) || (|wr_hits);
    assign hit_vec = {|wr_hits, |rd_hits, bp_hit};

    dbg_host_regs #(.AW(AW), .DW(DW), .NUM_WP(NUM_WP), .HAW(HAW), .HDW(HDW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .state_code (state),
        .busy       (busy),
        .hit_vec    (hit_vec),
        .cmd        (cmd),
        .bp_addr    (bp_addr),
        .bp_en      (bp_en),
        .wp_addr    (wp_addr),
        .wp_cfg     (wp_cfg),
        .wp_pat     (wp_pat)
    );

    dbg_exec_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .bp_hit       (bp_hit),
        .wp_hit       (wp_hit),
        .instr_done   (instr_done),
        .dbg_ack      (dbg_ack),
        .state        (state),
        .busy         (busy),
        .code_running (code_running),
        .cpu_skip     (cpu_skip),
        .debug_access (debug_access)
    );

    // R6
    bp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |=> !code_running);

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_awake && acc_valid) |=> ($past(code_running) == code_running || cpu_skip));
endmodule

// File: tb/tb_dbg_ctrl_unit.sv
module tb_dbg_ctrl_unit;
    logic        clk = 0, rst_n = 0;
    logic        host_we = 0;
    logic [3:0]  host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        fetch_valid = 0;
    logic [15:0] fetch_addr = 0;
    logic        instr_done = 0, acc_valid = 0, acc_write = 0, dbg_ack = 0;
    logic [1:0]  acc_space = 0;
    logic [15:0] acc_addr = 0;
    logic [7:0]  acc_data = 0;
    logic        code_running, cpu_skip, debug_access, cmp_awake;

    always #5 clk = ~clk;

    dbg_ctrl_unit dut (.*);

    // behavioural reference model
    int        m_st;       // 0 run, 1 halt, 2 step, 3 skip
    bit        m_busy;
    bit [2:0]  m_cause;
    bit [15:0] m_bpa;
    bit        m_bpe;
    bit [15:0] m_wa [2];
    bit [4:0]  m_wc [2];
    bit [7:0]  m_wp [2];
    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit finished = 0;

    function automatic bit awake_m();
        return m_bpe || (m_wc[0][1:0] != 0) || (m_wc[1][1:0] != 0);
    endfunction

    function automatic bit [15:0] read_m(bit [3:0] a);
        if (a == 1) return {9'd0, m_busy, 2'(m_st), 1'b0, m_cause};
        if (a == 2) return m_bpa;
        if (a == 3) return {15'd0, m_bpe};
        if (a == 4) return m_wa[0];
        if (a == 6) return m_wa[1];
        if (a == 5) return {m_wp[0], 3'd0, m_wc[0]};
        if (a == 7) return {m_wp[1], 3'd0, m_wc[1]};
        return 16'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_busy = 0; m_cause = 0; m_bpa = 0; m_bpe = 0;
            for (int i = 0; i < 2; i++) begin m_wa[i] = 0; m_wc[i] = 0; m_wp[i] = 0; end
        end else begin
            bit bp, rdh, wrh; int cmdv; int nst; bit nbusy;
            bp = awake_m() && m_bpe && m_st == 0 && fetch_valid && fetch_addr == m_bpa;
            rdh = 0; wrh = 0;
            for (int i = 0; i < 2; i++) begin
                if (awake_m() && (m_st == 0 || m_st == 2) && acc_valid
                    && acc_space == m_wc[i][3:2] && acc_addr == m_wa[i]
                    && (!m_wc[i][4] || acc_data == m_wp[i])) begin
                    if (!acc_write && m_wc[i][0]) rdh = 1;
                    if ( acc_write && m_wc[i][1]) wrh = 1;
                end
            end
            cmdv = (host_we && host_addr == 0) ? int'(host_wdata[2:0]) : 0;
            nst = m_st; nbusy = m_busy;
            if (m_busy && dbg_ack) nbusy = 0;
            case (m_st)
                0: if (cmdv == 2 || bp || rdh || wrh) nst = 1;
                2: if (cmdv == 2 || instr_done) nst = 1;
                3: nst = 1;
                default: if (!m_busy) begin
                    if (cmdv == 1) nst = 0;
                    else if (cmdv == 3) nst = 2;
                    else if (cmdv == 4) nst = 3;
                    else if (cmdv == 5) nbusy = 1;
                end
            endcase
            if (host_we && host_addr == 1) m_cause = m_cause & ~host_wdata[2:0];
            m_cause = m_cause | {wrh, rdh, bp};
            if (host_we) begin
                case (host_addr)
                    2: m_bpa = host_wdata;
                    3: m_bpe = host_wdata[0];
                    4: m_wa[0] = host_wdata;
                    6: m_wa[1] = host_wdata;
                    5: begin m_wc[0] = host_wdata[4:0]; m_wp[0] = host_wdata[15:8]; end
                    7: begin m_wc[1] = host_wdata[4:0]; m_wp[1] = host_wdata[15:8]; end
                    default: ;
                endcase
            end
            m_st = nst; m_busy = nbusy;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("code_running", code_running, (m_st == 0 || m_st == 2));
            chk("cpu_skip", cpu_skip, (m_st == 3));
            chk("debug_access", debug_access, m_busy);
            chk("cmp_awake", cmp_awake, awake_m());
            chk("host_rdata", host_rdata, read_m(host_addr));
        end
    end

    task automatic hw(int a, int d);
        @(posedge clk); #2; host_we = 1; host_addr = 4'(a); host_wdata = 16'(d);
        @(posedge clk); #2; host_we = 0;
    endtask
    task automatic sel(int a);
        @(posedge clk); #2; host_addr = 4'(a);
    endtask
    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask
    task automatic fetch(int a);
        @(posedge clk); #2; fetch_valid = 1; fetch_addr = 16'(a);
        @(posedge clk); #2; fetch_valid = 0;
    endtask
    task automatic bus(int sp, bit wr, int a, int d);
        @(posedge clk); #2; acc_valid = 1; acc_space = 2'(sp); acc_write = wr;
        acc_addr = 16'(a); acc_data = 8'(d);
        @(posedge clk); #2; acc_valid = 0;
    endtask
    task automatic done_pulse();
        @(posedge clk); #2; instr_done = 1; @(posedge clk); #2; instr_done = 0;
    endtask
    task automatic ack_pulse();
        @(posedge clk); #2; dbg_ack = 1; @(posedge clk); #2; dbg_ack = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk); #2; rst_n = 1;
        cur_req = "R1"; sel(1); idle(3);
        cur_req = "R12";
        hw(2, 16'h1234); idle(1); hw(4, 16'h0040); hw(6, 16'h0090);
        hw(5, 16'hA5E0); idle(1); hw(5, 16'h0000); sel(9); idle(1); sel(0); idle(1);
        cur_req = "R5"; sel(1);
        hw(0, 3); sel(1); hw(0, 4); sel(1); hw(0, 5); sel(1); hw(0, 1); sel(1); idle(2);
        cur_req = "R2"; hw(0, 2); sel(1); idle(3); hw(0, 1); sel(1); idle(2);
        cur_req = "R6"; hw(2, 16'h0100); hw(3, 1); sel(1);
        fetch(16'h00FF); idle(1); fetch(16'h0100); idle(2);
        cur_req = "R9"; hw(1, 0); sel(1); idle(1); hw(1, 1); sel(1); idle(1);
        cur_req = "R3"; hw(0, 3); sel(1); idle(2); fetch(16'h0100); idle(1);
        done_pulse(); idle(2);
        cur_req = "R4"; hw(0, 4); sel(1); idle(3);
        cur_req = "R10"; hw(0, 5); sel(1); idle(2);
        cur_req = "R5"; hw(0, 1); sel(1); hw(0, 3); sel(1);
        cur_req = "R10"; ack_pulse(); idle(2);
        cur_req = "R7"; hw(3, 0); hw(5, 16'h0005); hw(0, 1); sel(1);
        bus(1, 1, 16'h0040, 0); bus(0, 0, 16'h0040, 0); bus(1, 0, 16'h0041, 0); idle(1);
        bus(1, 0, 16'h0040, 8'h33); idle(2); hw(1, 7); sel(1);
        hw(7, 16'h000A); hw(0, 1); sel(1);
        bus(2, 0, 16'h0090, 0); bus(2, 1, 16'h0090, 0); idle(2); hw(1, 7);
        cur_req = "R8"; hw(7, 0); hw(5, 16'h5A17); hw(0, 1); sel(1);
        bus(1, 0, 16'h0040, 8'h11); bus(1, 1, 16'h0040, 8'h5B); idle(1);
        bus(1, 1, 16'h0040, 8'h5A); idle(2); hw(1, 7); sel(1);
        cur_req = "R11"; hw(5, 16'h5A00); sel(1); hw(0, 1); sel(1);
        bus(1, 1, 16'h0040, 8'h5A); fetch(16'h0100); idle(3);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule